// File: doc/BRIEF.md
# EEPROM Configuration Register with Shadow-Byte Remap

This block is the configuration register of an on-chip EEPROM controller, decoded on a simple byte-wide register bus. At reset its four upper bits are loaded from a non-volatile shadow byte. One of these bits controls the lockout of the background debug port. Another decides whether the array byte at one fixed address is replaced by the shadow byte. The two reserved test bits are reset-loaded the same way and can only be read. A further bit gates the module clock while the device waits.

The block has an address-substitution decoder. When substitution is active, reads and program/erase accesses aimed at array address 0x0FC0 are steered to the shadow byte, and bulk or row-wide program/erase operations include the shadow byte. The decoder also raises a warning when a program operation to the shadow byte would clear a test bit. Clearing a test bit hides part of the regular array. The EEPROM cells and the program/erase sequencer are outside this block.

Top module: `eecfg_ctrl`

## Requirements
- R1: The register is decoded at bus address 0x00F0. Its read layout is bit 7 debug-lockout disable, bit 6 shadow disable, bits 5:4 test bits, bit 2 wait-stop, and bits 3, 1 and 0 reading 0. Any other bus address reads 0x00.
- R2: While rst_n is low, each clock edge loads register bits 7:4 from shadow_byte[7:4] and clears wait-stop. After reset is released, the loaded value is held.
- R3: Bits 7 and 6 accept a bus write only when special_n is 0. Outside special mode they keep their value, and wait-stop from the same write still updates.
- R4: Bits 5:4 cannot be changed by a bus write in either mode.
- R5: dbg_lockout_en equals the inverse of bit 7, so 0 in bit 7 enables the lockout.
- R6: shadow_sel is 1 exactly when ee_addr equals 0x0FC0 and bit 6 is 0. It is combinational.
- R7: bulk_incl_shadow is 1 exactly when ee_bulk is 1 and bit 6 is 0.
- R8: test_warn is 1 when ee_pgm is 1, shadow_sel is 1 and ee_pgm_data[5:4] differs from the erased value 2'b11. Otherwise it is 0.
- R9: mod_clk_en is 0 exactly when wait_mode is 1 and wait-stop is 1.
- R10: A bus write is visible on bus_rdata and on every output from the cycle after its clock edge. Decodes made in the write cycle itself use the previous register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads from shadow_byte |
| bus_addr | input | 16 | Register bus address |
| bus_we | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data |
| shadow_byte | input | 8 | Non-volatile shadow byte contents |
| special_n | input | 1 | 0 = special mode (protected bits writable) |
| wait_mode | input | 1 | Device is in wait mode |
| ee_addr | input | 16 | EEPROM array access address |
| ee_pgm | input | 1 | Single-byte program in progress at ee_addr |
| ee_pgm_data | input | 8 | Data being programmed |
| ee_bulk | input | 1 | Bulk, odd-row or even-row program/erase request |
| shadow_sel | output | 1 | Access is steered to the shadow byte |
| bulk_incl_shadow | output | 1 | Bulk/row operation includes the shadow byte |
| test_warn | output | 1 | Program of the shadow byte would clear a test bit |
| dbg_lockout_en | output | 1 | Background debug lockout enabled |
| mod_clk_en | output | 1 | Module clock enable |

## Verification
Two functions can land in the same cycle. One is a bus write that flips the shadow disable bit. The other is an array access at 0x0FC0 that the remap decoder resolves. The bench holds ee_addr at 0x0FC0 while it issues the write in special mode. It samples shadow_sel before the clock edge, where the old bit must still rule, and after the edge, where the new bit must rule. The same check is made for a wait-stop write issued while wait_mode is high: the clock enable must change only after the edge.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;
   localparam int DATA_W   = 8;
   localparam int BIT_DBG  = 7;
   localparam int BIT_SHD  = 6;
   localparam int BIT_TST1 = 5;
   localparam int BIT_TST0 = 4;
   localparam int BIT_WAIT = 2;

   typedef struct packed {
      logic       dbg_off;
      logic       shadow_off;
      logic [1:0] test;
      logic       rsv3;
      logic       wait_stop;
      logic [1:0] rsv10;
   } cfg_t;
endpackage

// File: rtl/eecfg_regfile.sv
module eecfg_regfile
   import eecfg_pkg::*;
#(
   parameter int                ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'h00F0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] shadow_byte,
   input  logic              special_n,
   output cfg_t              cfg,
   output logic [DATA_W-1:0] rdata
);
   logic hit;
   logic wr;
   logic prot_ok;

   assign hit     = (bus_addr == REG_ADDR);
   assign wr      = hit && bus_we;
   assign prot_ok = !special_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg            <= '0;
         cfg.dbg_off    <= shadow_byte[BIT_DBG];
         cfg.shadow_off <= shadow_byte[BIT_SHD];
         cfg.test       <= shadow_byte[BIT_TST1:BIT_TST0];
      end else if (wr) begin
         if (prot_ok) begin
            cfg.dbg_off    <= bus_wdata[BIT_DBG];
            cfg.shadow_off <= bus_wdata[BIT_SHD];
         end
         cfg.wait_stop <= bus_wdata[BIT_WAIT];
      end
   end

   assign rdata = hit ? DATA_W'(cfg) : '0;

   AST_RESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cfg[7:4] == $past(shadow_byte[7:4]) && !cfg.wait_stop)); // R2
   AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (special_n && $past(rst_n)) |=> ($stable(cfg.dbg_off) && $stable(cfg.shadow_off))); // R3
   AST_TEST_RO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(cfg.test)); // R4
   AST_WAIT_WR: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (cfg.wait_stop == $past(bus_wdata[BIT_WAIT]))); // R10
endmodule

// File: rtl/eecfg_remap.sv
module eecfg_remap
   import eecfg_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] SHADOW_ADDR = 'h0FC0,
   parameter logic [1:0]        TEST_SAFE   = 2'b11,
   parameter bit                REMAP_EN    = 1'b1
) (
   input  logic [ADDR_W-1:0] ee_addr,
   input  logic              ee_pgm,
   input  logic [DATA_W-1:0] ee_pgm_data,
   input  logic              ee_bulk,
   input  logic              shadow_off,
   output logic              shadow_sel,
   output logic              bulk_incl_shadow,
   output logic              test_warn
);
   logic addr_match;
   assign addr_match = (ee_addr == SHADOW_ADDR);

   generate
      if (REMAP_EN) begin : g_remap
         assign shadow_sel       = addr_match && !shadow_off;
         assign bulk_incl_shadow = ee_bulk && !shadow_off;
      end else begin : g_no_remap
         assign shadow_sel       = 1'b0;
         assign bulk_incl_shadow = 1'b0;
      end
   endgenerate

   assign test_warn = ee_pgm && shadow_sel &&
                      (ee_pgm_data[BIT_TST1:BIT_TST0] != TEST_SAFE);

   always_comb begin
      AST_SEL_ADDR: assert (!shadow_sel || addr_match); // R6
      AST_WARN_SHADOW: assert (!test_warn || (shadow_sel && ee_pgm)); // R8
   end
endmodule

// File: rtl/eecfg_clkgate.sv
module eecfg_clkgate (
   input  logic wait_mode,
   input  logic wait_stop,
   output logic mod_clk_en
);
   assign mod_clk_en = !(wait_mode && wait_stop);

   always_comb begin
      AST_CLK_RUN: assert (wait_mode || mod_clk_en); // R9
   end
endmodule

// File: rtl/eecfg_ctrl.sv
module eecfg_ctrl
   import eecfg_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] REG_ADDR    = 'h00F0,
   parameter logic [ADDR_W-1:0] SHADOW_ADDR = 'h0FC0,
   parameter logic [1:0]        TEST_SAFE   = 2'b11,
   parameter bit                REMAP_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [7:0]        shadow_byte,
   input  logic              special_n,
   input  logic              wait_mode,
   input  logic [ADDR_W-1:0] ee_addr,
   input  logic              ee_pgm,
   input  logic [7:0]        ee_pgm_data,
   input  logic              ee_bulk,
   output logic              shadow_sel,
   output logic              bulk_incl_shadow,
   output logic              test_warn,
   output logic              dbg_lockout_en,
   output logic              mod_clk_en
);
   generate
      if (ADDR_W < 12) begin : g_bad_width
         $error("eecfg_ctrl: ADDR_W too narrow for shadow address");
      end
      if (REG_ADDR == SHADOW_ADDR) begin : g_bad_map
         $error("eecfg_ctrl: register and shadow addresses collide");
      end
   endgenerate

   cfg_t cfg;

   eecfg_regfile #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .shadow_byte(shadow_byte), .special_n(special_n),
      .cfg(cfg), .rdata(bus_rdata)
   );

   eecfg_remap #(.ADDR_W(ADDR_W), .SHADOW_ADDR(SHADOW_ADDR),
                 .TEST_SAFE(TEST_SAFE), .REMAP_EN(REMAP_EN)) u_remap (
      .ee_addr(ee_addr), .ee_pgm(ee_pgm), .ee_pgm_data(ee_pgm_data),
      .ee_bulk(ee_bulk), .shadow_off(cfg.shadow_off),
      .shadow_sel(shadow_sel), .bulk_incl_shadow(bulk_incl_shadow),
      .test_warn(test_warn)
   );

   eecfg_clkgate u_gate (
      .wait_mode(wait_mode), .wait_stop(cfg.wait_stop), .mod_clk_en(mod_clk_en)
   );

   assign dbg_lockout_en = !cfg.dbg_off;

   AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == REG_ADDR && !special_n) |=>
         (dbg_lockout_en == !$past(bus_wdata[BIT_DBG]))); // R5
   AST_BULK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !ee_bulk |-> !bulk_incl_shadow); // R7
endmodule

// File: tb/sim_eecfg_ctrl.sv
module sim_eecfg_ctrl;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [7:0]  shadow_byte = 8'hFF;
   logic        special_n = 1'b1;
   logic        wait_mode = 1'b0;
   logic [15:0] ee_addr = '0;
   logic        ee_pgm = 1'b0;
   logic [7:0]  ee_pgm_data = 8'hFF;
   logic        ee_bulk = 1'b0;
   logic        shadow_sel, bulk_incl_shadow, test_warn, dbg_lockout_en, mod_clk_en;

   int total = 0;
   int bad = 0;

   always #(CLK_P/2) clk = ~clk;

   eecfg_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .shadow_byte(shadow_byte),
      .special_n(special_n), .wait_mode(wait_mode), .ee_addr(ee_addr),
      .ee_pgm(ee_pgm), .ee_pgm_data(ee_pgm_data), .ee_bulk(ee_bulk),
      .shadow_sel(shadow_sel), .bulk_incl_shadow(bulk_incl_shadow),
      .test_warn(test_warn), .dbg_lockout_en(dbg_lockout_en),
      .mod_clk_en(mod_clk_en)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic rd_cfg(output logic [7:0] v);
      bus_addr = 16'h00F0;
      #1 v = bus_rdata;
   endtask

   task automatic wr_cfg(input logic [7:0] d);
      @(negedge clk);
      bus_addr = 16'h00F0; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic t_reset(input logic [7:0] sh);
      logic [7:0] v;
      @(negedge clk);
      rst_n = 1'b0; shadow_byte = sh;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      shadow_byte = ~sh;
      @(posedge clk); @(negedge clk);
      rd_cfg(v);
      check("R2 reset load", v, {sh[7:4], 4'b0000});
      check("R5 lockout after reset", {7'd0, dbg_lockout_en}, {7'd0, !sh[7]});
   endtask

   task automatic t_decode_other;
      bus_addr = 16'h00F1;
      #1 check("R1 other address reads zero", bus_rdata, 8'h00);
   endtask

   task automatic t_prot_user;
      logic [7:0] v;
      special_n = 1'b1;
      wr_cfg(8'h3F);
      rd_cfg(v);
      // prior bits7:4 = 1100 from last reset pattern
      check("R3 protected hold, wait updates", v, 8'hC4);
      check("R1 unused bits zero", v & 8'h0B, 8'h00);
   endtask

   task automatic t_prot_special;
      logic [7:0] v;
      special_n = 1'b0;
      wr_cfg(8'h00);
      rd_cfg(v);
      check("R3 special write bits 7:6", v, 8'h00);
      check("R4 test bits unchanged", v & 8'h30, 8'h00);
      check("R5 lockout enabled", {7'd0, dbg_lockout_en}, 8'h01);
      wr_cfg(8'hF0);
      rd_cfg(v);
      check("R4 test bits ignore write", v, 8'hC0);
      check("R5 lockout disabled", {7'd0, dbg_lockout_en}, 8'h00);
   endtask

   task automatic t_remap;
      special_n = 1'b0;
      wr_cfg(8'h00); // shadow enabled
      ee_addr = 16'h0FC0; #1
      check("R6 shadow selected", {7'd0, shadow_sel}, 8'h01);
      ee_addr = 16'h0FC1; #1
      check("R6 neighbour not selected", {7'd0, shadow_sel}, 8'h00);
      ee_bulk = 1'b1; #1
      check("R7 bulk includes shadow", {7'd0, bulk_incl_shadow}, 8'h01);
      ee_addr = 16'h0FC0; ee_pgm = 1'b1; ee_pgm_data = 8'hEF; #1
      check("R8 warn on test bit clear", {7'd0, test_warn}, 8'h01);
      ee_pgm_data = 8'h3F; #1
      check("R8 no warn when test bits erased", {7'd0, test_warn}, 8'h00);
      ee_pgm_data = 8'h00; ee_addr = 16'h0FC4; #1
      check("R8 no warn off shadow", {7'd0, test_warn}, 8'h00);
      ee_addr = 16'h0FC0;
      wr_cfg(8'h40); // shadow disabled
      #1 check("R6 disabled remap", {7'd0, shadow_sel}, 8'h00);
      check("R7 bulk excludes shadow", {7'd0, bulk_incl_shadow}, 8'h00);
      check("R8 no warn when disabled", {7'd0, test_warn}, 8'h00);
      ee_bulk = 1'b0; ee_pgm = 1'b0;
   endtask

   task automatic t_same_cycle;
      special_n = 1'b0;
      ee_addr = 16'h0FC0;
      @(negedge clk);
      bus_addr = 16'h00F0; bus_wdata = 8'h00; bus_we = 1'b1;
      #1 check("R10 old value in write cycle", {7'd0, shadow_sel}, 8'h00);
      @(posedge clk); @(negedge clk);
      bus_we = 1'b0;
      check("R10 new value after edge", {7'd0, shadow_sel}, 8'h01);
   endtask

   task automatic t_clkgate;
      special_n = 1'b1;
      wr_cfg(8'h00);
      wait_mode = 1'b1; #1
      check("R9 wait, stop clear runs", {7'd0, mod_clk_en}, 8'h01);
      @(negedge clk);
      bus_addr = 16'h00F0; bus_wdata = 8'h04; bus_we = 1'b1;
      #1 check("R10 gate before edge", {7'd0, mod_clk_en}, 8'h01);
      @(posedge clk); @(negedge clk);
      bus_we = 1'b0;
      check("R9 wait and stop gates", {7'd0, mod_clk_en}, 8'h00);
      wait_mode = 1'b0; #1
      check("R9 run outside wait", {7'd0, mod_clk_en}, 8'h01);
   endtask

   initial begin : watchdog
      #(CLK_P * 5000);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset(8'hA5);
      t_reset(8'h5A);
      t_reset(8'hC3);
      t_decode_other;
      t_prot_user;
      t_prot_special;
      t_remap;
      t_same_cycle;
      t_clkgate;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule